// File: doc/BRIEF.md
# Parallel Compare-and-Reduce Engine

The engine takes one slice of `W` unsigned elements and a scalar target, compares every element against the target in the same cycle, and folds the resulting lane bits through a balanced binary tree. Each tree node computes three things at once. It adds the two child counts. It ORs the two child hit flags. It picks the index of the lower-numbered matching child. One tree therefore yields a population count, an any-match flag and a first-match position for the same slice.

A one-bit mode travels with each slice. In count mode a lane bit is set when the element is greater than or equal to the target; this suits histogram and pointer-array construction. In filter mode a lane bit is set only on equality; this suits membership lookup and reindexing. Optional registers can be placed after the comparator stage and after any chosen tree level. The latency is fixed by those parameters, and the engine always accepts one slice per clock.

Top module: `cmp_reduce_engine`

## Requirements
- R1: Lane `i` occupies bits `[i*DW +: DW]` of `in_elems`. With `in_mode` = 0 (count mode), a lane is selected when its element is greater than or equal to `in_target`, both treated as unsigned, and `out_count` is the number of selected lanes.
- R2: With `in_mode` = 1 (filter mode), a lane is selected only when its element equals `in_target`, and `out_count` is the number of equal lanes.
- R3: `out_hit` is 1 exactly when at least one lane of the slice is selected.
- R4: `out_index` is the lowest-numbered selected lane. When no lane is selected, both `out_index` and `out_count` are 0.
- R5: `out_count` is `log2(W)+1` bits wide and reports `W` when every lane is selected.
- R6: A slice accepted at a clock edge appears on the outputs exactly `CMP_REG + (number of set bits of TREE_REG_MASK)` edges later, independent of the data. Slices accepted on consecutive edges come out on consecutive edges, in order.
- R7: `out_mode` returns the mode of the slice being reported. Back-to-back slices may alternate modes, and each is reduced under its own mode.
- R8: `in_ready` is 0 while `rst_n` is low and is 1 from the first clock edge after reset is released. `out_valid` is 0 during reset, and it pulses only for slices accepted with `in_valid` and `in_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Slice present on the input |
| in_ready | output | 1 | Engine accepts a slice this cycle |
| in_mode | input | 1 | 0 = count (greater or equal), 1 = filter (equal) |
| in_target | input | DW | Scalar compared with every lane |
| in_elems | input | W*DW | Packed element vector, lane 0 in the low bits |
| out_valid | output | 1 | Result present on the outputs |
| out_mode | output | 1 | Mode of the reported slice |
| out_count | output | $clog2(W)+1 | Number of selected lanes |
| out_hit | output | 1 | Any lane selected |
| out_index | output | $clog2(W) | Lowest selected lane, 0 if none |

## Verification
The bench builds the engine with `W` = 8, `DW` = 32, the comparator register enabled and `TREE_REG_MASK` = 5. That gives a latency of three edges, with registers at the comparator stage, after tree level 0 and after tree level 2, so both registered and pass-through tree levels are exercised. The narrow lane count makes equality matches common under random data drawn from a small value range. It also makes the all-lanes count and the highest lane index easy to reach. Full-range 32-bit values are mixed in to exercise the unsigned comparison at both ends of the range.

// File: rtl/cre_pkg.sv
package cre_pkg;

   typedef enum logic {
      MODE_COUNT  = 1'b0,
      MODE_FILTER = 1'b1
   } cre_mode_e;

   // number of pipeline registers enabled in the tree mask, over the used levels
   function automatic int tree_stage_count(input int unsigned mask, input int levels);
      int n;
      n = 0;
      for (int k = 0; k < levels; k++) begin
         if (((mask >> k) & 1) != 0) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/cre_lane_cmp.sv
module cre_lane_cmp
   import cre_pkg::*;
#(
   parameter int W   = 64,
   parameter int DW  = 32,
   parameter bit REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            in_mode,
   input  logic [DW-1:0]   in_target,
   input  logic [W*DW-1:0] in_elems,
   output logic            out_valid,
   output logic            out_mode,
   output logic [W-1:0]    out_bits
);

   logic [W-1:0] sel_d;

   // one subtractor per lane serves both the ordering and the equality test
   for (genvar i = 0; i < W; i++) begin : g_lane
      logic [DW:0] diff;
      logic        ge;
      logic        eq;
      assign diff     = {1'b0, in_elems[i*DW +: DW]} - {1'b0, in_target};
      assign ge       = ~diff[DW];
      assign eq       = (diff[DW-1:0] == '0);
      assign sel_d[i] = (in_mode == MODE_FILTER) ? eq : ge;
   end

   if (REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_mode  <= 1'b0;
            out_bits  <= '0;
         end else begin
            out_valid <= in_valid;
            out_mode  <= in_mode;
            out_bits  <= sel_d;
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_mode  = in_mode;
      assign out_bits  = sel_d;
   end

endmodule

// File: rtl/cre_tree_level.sv
module cre_tree_level #(
   parameter int N_IN = 2,
   parameter int CW   = 2,
   parameter int IW   = 1,
   parameter int LVL  = 0,
   parameter bit REG  = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_mode,
   input  logic [N_IN*CW-1:0]      in_cnt,
   input  logic [N_IN-1:0]         in_hit,
   input  logic [N_IN*IW-1:0]      in_idx,
   output logic                    out_valid,
   output logic                    out_mode,
   output logic [(N_IN/2)*CW-1:0]  out_cnt,
   output logic [N_IN/2-1:0]       out_hit,
   output logic [(N_IN/2)*IW-1:0]  out_idx
);

   localparam int N_OUT = N_IN / 2;

   logic [N_OUT*CW-1:0] cnt_d;
   logic [N_OUT-1:0]    hit_d;
   logic [N_OUT*IW-1:0] idx_d;

   for (genvar n = 0; n < N_OUT; n++) begin : g_node
      logic [IW-1:0] upper_tag;
      always_comb begin
         upper_tag      = in_idx[(2*n+1)*IW +: IW];
         upper_tag[LVL] = 1'b1;
      end
      assign cnt_d[n*CW +: CW] = in_cnt[(2*n)*CW +: CW] + in_cnt[(2*n+1)*CW +: CW];
      assign hit_d[n]          = in_hit[2*n] | in_hit[2*n+1];
      assign idx_d[n*IW +: IW] = in_hit[2*n]   ? in_idx[(2*n)*IW +: IW] :
                                 in_hit[2*n+1] ? upper_tag : '0;
   end

   if (REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_mode  <= 1'b0;
            out_cnt   <= '0;
            out_hit   <= '0;
            out_idx   <= '0;
         end else begin
            out_valid <= in_valid;
            out_mode  <= in_mode;
            out_cnt   <= cnt_d;
            out_hit   <= hit_d;
            out_idx   <= idx_d;
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign out_mode  = in_mode;
      assign out_cnt   = cnt_d;
      assign out_hit   = hit_d;
      assign out_idx   = idx_d;
   end

endmodule

// File: rtl/cmp_reduce_engine.sv
module cmp_reduce_engine
   import cre_pkg::*;
#(
   parameter int          W             = 64,
   parameter int          DW            = 32,
   parameter bit          CMP_REG       = 1'b1,
   parameter int unsigned TREE_REG_MASK = 32'h2A
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic                 in_mode,
   input  logic [DW-1:0]        in_target,
   input  logic [W*DW-1:0]      in_elems,
   output logic                 out_valid,
   output logic                 out_mode,
   output logic [$clog2(W):0]   out_count,
   output logic                 out_hit,
   output logic [$clog2(W)-1:0] out_index
);

   localparam int LOGW    = $clog2(W);
   localparam int CW      = LOGW + 1;
   localparam int IW      = LOGW;
   localparam int LATENCY = int'(CMP_REG) + tree_stage_count(TREE_REG_MASK, LOGW);

   // elaboration-time parameter checks
   if (W < 2 || (1 << LOGW) != W) begin : g_bad_w
      $error("cmp_reduce_engine: W must be a power of two and at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("cmp_reduce_engine: DW must be at least 1");
   end
   if (LOGW < 32 && (TREE_REG_MASK >> LOGW) != 0) begin : g_bad_mask
      $error("cmp_reduce_engine: TREE_REG_MASK has bits above the tree depth");
   end

   logic ready_q;
   always_ff @(posedge clk) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= 1'b1;
   end
   assign in_ready = ready_q;

   logic accept;
   assign accept = in_valid & ready_q;

   logic         cmp_valid;
   logic         cmp_mode;
   logic [W-1:0] cmp_bits;

   cre_lane_cmp #(
      .W   (W),
      .DW  (DW),
      .REG (CMP_REG)
   ) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (accept),
      .in_mode   (in_mode),
      .in_target (in_target),
      .in_elems  (in_elems),
      .out_valid (cmp_valid),
      .out_mode  (cmp_mode),
      .out_bits  (cmp_bits)
   );

   // leaves: every lane is a node with count 0/1, hit = lane bit, index 0
   logic [W*CW-1:0] leaf_cnt;
   logic [W*IW-1:0] leaf_idx;
   for (genvar i = 0; i < W; i++) begin : g_leaf
      assign leaf_cnt[i*CW +: CW] = CW'(cmp_bits[i]);
      assign leaf_idx[i*IW +: IW] = '0;
   end

   for (genvar l = 0; l < LOGW; l++) begin : g_lvl
      localparam int NI = W >> l;
      localparam int NO = NI / 2;
      localparam bit LREG = ((TREE_REG_MASK >> l) & 1) != 0;

      logic             vi;
      logic             mi;
      logic [NI*CW-1:0] ci;
      logic [NI-1:0]    hi;
      logic [NI*IW-1:0] xi;
      logic             vo;
      logic             mo;
      logic [NO*CW-1:0] co;
      logic [NO-1:0]    ho;
      logic [NO*IW-1:0] xo;

      if (l == 0) begin : g_src
         assign vi = cmp_valid;
         assign mi = cmp_mode;
         assign ci = leaf_cnt;
         assign hi = cmp_bits;
         assign xi = leaf_idx;
      end else begin : g_src
         assign vi = g_lvl[l-1].vo;
         assign mi = g_lvl[l-1].mo;
         assign ci = g_lvl[l-1].co;
         assign hi = g_lvl[l-1].ho;
         assign xi = g_lvl[l-1].xo;
      end

      cre_tree_level #(
         .N_IN (NI),
         .CW   (CW),
         .IW   (IW),
         .LVL  (l),
         .REG  (LREG)
      ) u_level (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_valid  (vi),
         .in_mode   (mi),
         .in_cnt    (ci),
         .in_hit    (hi),
         .in_idx    (xi),
         .out_valid (vo),
         .out_mode  (mo),
         .out_cnt   (co),
         .out_hit   (ho),
         .out_idx   (xo)
      );
   end

   assign out_valid = g_lvl[LOGW-1].vo;
   assign out_mode  = g_lvl[LOGW-1].mo;
   assign out_count = g_lvl[LOGW-1].co;
   assign out_hit   = g_lvl[LOGW-1].ho[0];
   assign out_index = g_lvl[LOGW-1].xo;

endmodule

// File: rtl/cre_engine_chk.sv
module cre_engine_chk #(
   parameter int W   = 64,
   parameter int LAT = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 in_ready,
   input logic                 in_mode,
   input logic                 out_valid,
   input logic                 out_mode,
   input logic [$clog2(W):0]   out_count,
   input logic                 out_hit,
   input logic [$clog2(W)-1:0] out_index
);

   logic acc;
   assign acc = in_valid & in_ready;

   // R5
   count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_count <= ($clog2(W)+1)'(W)));

   // R3
   hit_matches_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_hit == (out_count != '0)));

   // R4
   miss_zero_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_hit) |-> (out_index == '0));

   if (LAT == 0) begin : g_lat0
      // R6
      fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == acc);
      // R7
      mode_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (out_mode == in_mode));
   end else begin : g_latn
      logic [LAT-1:0] v_hist;
      logic [LAT-1:0] m_hist;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_hist <= '0;
            m_hist <= '0;
         end else begin
            v_hist <= (v_hist << 1) | LAT'(acc);
            m_hist <= (m_hist << 1) | LAT'(in_mode);
         end
      end
      // R6
      fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == v_hist[LAT-1]);
      // R7
      mode_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (out_mode == m_hist[LAT-1]));
   end

endmodule

bind cmp_reduce_engine cre_engine_chk #(
   .W   (W),
   .LAT (LATENCY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_mode   (in_mode),
   .out_valid (out_valid),
   .out_mode  (out_mode),
   .out_count (out_count),
   .out_hit   (out_hit),
   .out_index (out_index)
);

// File: tb/cmp_reduce_engine_tb_top.sv
`timescale 1ns/1ps
module cmp_reduce_engine_tb_top;

   localparam int          W     = 8;
   localparam int          DW    = 32;
   localparam int          LOGW  = $clog2(W);
   localparam bit          CREG  = 1'b1;
   localparam int unsigned TMASK = 32'h5;
   localparam int          LAT   = 3;
   localparam int          NRAND = 3000;

   typedef struct packed {
      logic [LOGW:0]   cnt;
      logic            hit;
      logic [LOGW-1:0] idx;
      logic            mode;
      int              due;
   } exp_t;

   logic                clk;
   logic                rst_n;
   logic                in_valid;
   logic                in_ready;
   logic                in_mode;
   logic [DW-1:0]       in_target;
   logic [W*DW-1:0]     in_elems;
   logic                out_valid;
   logic                out_mode;
   logic [LOGW:0]       out_count;
   logic                out_hit;
   logic [LOGW-1:0]     out_index;

   int   cyc;
   int   checks;
   int   fails;
   bit   done;
   exp_t pend[$];

   cmp_reduce_engine #(
      .W             (W),
      .DW            (DW),
      .CMP_REG       (CREG),
      .TREE_REG_MASK (TMASK)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_mode   (in_mode),
      .in_target (in_target),
      .in_elems  (in_elems),
      .out_valid (out_valid),
      .out_mode  (out_mode),
      .out_count (out_count),
      .out_hit   (out_hit),
      .out_index (out_index)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   initial cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // reference model built from R1, R2, R3, R4
   function automatic exp_t model(input logic mode, input logic [DW-1:0] t,
                                  input logic [W*DW-1:0] e);
      exp_t r;
      r = '0;
      r.mode = mode;
      for (int i = W - 1; i >= 0; i--) begin
         logic s;
         s = mode ? (e[i*DW +: DW] == t) : (e[i*DW +: DW] >= t);
         if (s) begin
            r.cnt = r.cnt + 1'b1;
            r.hit = 1'b1;
            r.idx = LOGW'(i);
         end
      end
      return r;
   endfunction

   task automatic check_outputs();
      if (pend.size() != 0 && pend[0].due == cyc) begin
         exp_t x;
         x = pend.pop_front();
         checks++;
         if (!out_valid) begin
            fails++;
            $display("FAIL R6: out_valid=%0b expected 1 at cycle %0d", out_valid, cyc);
         end else if (out_count != x.cnt || out_hit != x.hit || out_index != x.idx ||
                      out_mode != x.mode) begin
            fails++;
            $display("FAIL R1/R2/R3/R4/R7 mode %0b: count=%0d hit=%0b idx=%0d mode=%0b expected count=%0d hit=%0b idx=%0d mode=%0b",
                     x.mode, out_count, out_hit, out_index, out_mode,
                     x.cnt, x.hit, x.idx, x.mode);
         end
      end else if (out_valid) begin
         checks++;
         fails++;
         $display("FAIL R8: out_valid=1 expected 0 at cycle %0d", cyc);
      end
   endtask

   task automatic step(input logic v, input logic m, input logic [DW-1:0] t,
                       input logic [W*DW-1:0] e);
      @(negedge clk);
      check_outputs();
      in_valid  = v;
      in_mode   = m;
      in_target = t;
      in_elems  = e;
      if (v && in_ready) begin
         exp_t x;
         x     = model(m, t, e);
         x.due = cyc + LAT;
         pend.push_back(x);
      end
   endtask

   function automatic logic [W*DW-1:0] fill(input logic [DW-1:0] val);
      logic [W*DW-1:0] e;
      for (int i = 0; i < W; i++) e[i*DW +: DW] = val;
      return e;
   endfunction

   function automatic logic [DW-1:0] rnd_val();
      int unsigned sel;
      sel = $urandom % 8;
      if (sel < 5)       return DW'($urandom % 8);
      else if (sel == 5) return {DW{1'b1}};
      else               return DW'($urandom);
   endfunction

   initial begin
      logic [W*DW-1:0] e;
      void'($urandom(32'h1234_5eed));
      checks    = 0;
      fails     = 0;
      done      = 1'b0;
      rst_n     = 1'b0;
      in_valid  = 1'b0;
      in_mode   = 1'b0;
      in_target = '0;
      in_elems  = '0;

      // R8: reset state
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         checks++;
         if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
            fails++;
            $display("FAIL R8: out_valid=%0b in_ready=%0b expected 0 0 in reset",
                     out_valid, in_ready);
         end
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (in_ready !== 1'b1) begin
         fails++;
         $display("FAIL R8: in_ready=%0b expected 1 after reset", in_ready);
      end

      // R5: target 0 selects every lane
      step(1'b1, 1'b0, '0, fill(32'd17));
      // R5, R1: extreme top of range
      step(1'b1, 1'b0, {DW{1'b1}}, fill({DW{1'b1}}));
      // R4: nothing reaches the target
      step(1'b1, 1'b0, {DW{1'b1}}, fill({{(DW-1){1'b1}}, 1'b0}));
      // R2, R4: several equal lanes, lowest reported
      e = fill(32'd9);
      e[3*DW +: DW] = 32'd42; e[5*DW +: DW] = 32'd42; e[6*DW +: DW] = 32'd42;
      step(1'b1, 1'b1, 32'd42, e);
      // R2, R4: no equality although many lanes are greater
      step(1'b1, 1'b1, 32'd5, fill(32'd6));
      // R4: only the highest lane matches
      e = fill(32'd1);
      e[(W-1)*DW +: DW] = 32'd77;
      step(1'b1, 1'b1, 32'd77, e);
      // R7: same data, alternating modes back to back
      step(1'b1, 1'b0, 32'd77, e);
      e = fill(32'd3);
      e[5*DW +: DW] = 32'd100;
      step(1'b1, 1'b0, 32'd50, e);
      step(1'b1, 1'b1, 32'd3, e);
      // R8: bubbles produce no output
      step(1'b0, 1'b1, 32'd3, e);
      step(1'b0, 1'b0, '0, e);
      // R6: back-to-back after a bubble
      step(1'b1, 1'b1, 32'd100, e);

      // random slices covering R1, R2, R3, R4, R6, R7, R8
      for (int n = 0; n < NRAND; n++) begin
         logic [W*DW-1:0] re;
         logic [DW-1:0]   rt;
         for (int i = 0; i < W; i++) re[i*DW +: DW] = rnd_val();
         rt = rnd_val();
         step(($urandom % 5) != 0, 1'(($urandom % 2)), rt, re);
      end

      for (int k = 0; k < LAT + 3; k++) step(1'b0, 1'b0, '0, '0);
      if (pend.size() != 0) begin
         checks++;
         fails++;
         $display("FAIL R6: %0d results missing, expected 0", pend.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule